// File: doc/BRIEF.md
# Channel Counting Semaphore Controller

This block keeps an 8-bit counting semaphore for a single DMA command channel. Software and the descriptor engine use it to agree on how many descriptors may run. Software raises the count by writing an amount to the increment register. It drops the count to zero with a keyed write to a separate clear port. The engine holds a decrement request after each descriptor that carries its decrement flag. The block grants that request when the count allows it and stalls the engine while the count is zero. A stalled request stays pending, so it is never lost.

A software add and an engine decrement in the same clock merge into one net update, so neither is lost. An error reported by the engine drops the count to zero. The channel reports itself active while the count is above zero.

Top module: `chan_sema_ctrl`

## Requirements
- R1: After reset the count is 0, `chan_active` is low, and `dec_grant` and `dec_stall` are low while no request is present.
- R2: A cycle with `inc_wr_en` high adds `inc_wr_data[7:0]` to the count. Bits 31:8 of the written word have no effect.
- R3: When an add and a granted decrement fall in the same cycle, the count changes by the added value minus one in that cycle. For example, adding 2 gives a net change of +1.
- R4: The count saturates at 255. An add that would exceed 255 leaves the count at 255, and this applies after the same-cycle decrement has been netted in.
- R5: `reg_rd_data` carries the count in bits 23:16 and zero in every other bit, including the write-only increment field in bits 7:0.
- R6: A cycle with `clr_wr_en` high and `clr_wr_data` equal to 0xFF sets the count to 0. A clear write with any other value leaves the count unchanged.
- R7: A cycle with `eng_err` high sets the count to 0.
- R8: A qualifying clear or an error takes priority over a same-cycle add and over a same-cycle decrement. The count becomes 0 and `dec_grant` stays low in that cycle.
- R9: `chan_active` is high exactly when the count is non-zero.
- R10: While `dec_req` is high, `dec_grant` is high in any cycle where the count is non-zero or the same-cycle add is non-zero, unless R8 applies. Each grant lowers the count by one.
- R11: `dec_stall` is high whenever `dec_req` is high and no grant is given. A request made at count zero stays stalled, with the count held at zero, until software adds to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inc_wr_en | input | 1 | Write strobe of the increment register |
| inc_wr_data | input | 32 | Write data of the increment register; bits 7:0 are the add amount |
| reg_rd_data | output | 32 | Read view: count in bits 23:16, zero elsewhere |
| clr_wr_en | input | 1 | Write strobe of the clear register |
| clr_wr_data | input | 8 | Clear key; 0xFF clears the count |
| dec_req | input | 1 | Engine decrement request, held until granted |
| dec_grant | output | 1 | Decrement accepted this cycle |
| dec_stall | output | 1 | Request pending but not granted this cycle |
| eng_err | input | 1 | Engine error; clears the count |
| chan_active | output | 1 | Count is non-zero |

## Verification
The assertions assume that the engine holds `dec_req` high until it sees `dec_grant`, and that the inputs change only away from the rising edge. The grant and decrement checks also assume that `inc_wr_en` is low in cycles where it carries no amount. The bench drives every input on the falling edge. It releases each request only after observing its grant, or only after finishing the stall scenario it is checking. It combines adds, decrements, clears and errors in the same cycle only in the scenarios that target net updates and priority.

// File: rtl/chan_sema_pkg.sv
package chan_sema_pkg;
  localparam int unsigned SEMA_CNT_W  = 8;
  localparam int unsigned SEMA_REG_W  = 32;
  localparam int unsigned SEMA_CNT_LSB = 16;

  typedef struct packed {
    logic kill;
    logic grant;
  } sema_ctl_t;
endpackage

// File: rtl/sema_regif.sv
module sema_regif
  import chan_sema_pkg::*;
#(
  parameter int unsigned CNT_W   = SEMA_CNT_W,
  parameter int unsigned REG_W   = SEMA_REG_W,
  parameter int unsigned CNT_LSB = SEMA_CNT_LSB
) (
  input  logic             inc_wr_en,
  input  logic [REG_W-1:0] inc_wr_data,
  input  logic             clr_wr_en,
  input  logic [CNT_W-1:0] clr_wr_data,
  input  logic             eng_err,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] add_val,
  output logic             kill,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] CLR_KEY = '1;

  always_comb begin
    add_val = inc_wr_en ? inc_wr_data[CNT_W-1:0] : '0;
    kill    = eng_err | (clr_wr_en & (clr_wr_data == CLR_KEY));
  end

  always_comb begin
    rd_data = '0;
    rd_data[CNT_LSB +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/sema_grant.sv
module sema_grant #(
  parameter int unsigned CNT_W = chan_sema_pkg::SEMA_CNT_W
) (
  input  logic             dec_req,
  input  logic             kill,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] add_val,
  output logic             grant,
  output logic             stall
);
  logic credit_avail;

  always_comb begin
    credit_avail = (cnt_q != '0) || (add_val != '0);
    grant        = dec_req & ~kill & credit_avail;
    stall        = dec_req & ~grant;
  end
endmodule

// File: rtl/sema_counter.sv
module sema_counter #(
  parameter int unsigned CNT_W = chan_sema_pkg::SEMA_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] add_val,
  input  logic             grant,
  input  logic             kill,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int unsigned SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SUM_W-1:0] net_sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    net_sum = {1'b0, cnt_q} + {1'b0, add_val} - SUM_W'(grant);
    cnt_en  = kill | grant | (add_val != '0);
    if (kill)
      cnt_d = '0;
    else if (net_sum[CNT_W])
      cnt_d = CNT_MAX;
    else
      cnt_d = net_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  a_r6_kill_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (cnt_q == '0));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && !grant && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  a_r10_single_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && grant && add_val == '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && !grant && add_val == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/chan_sema_ctrl.sv
module chan_sema_ctrl
  import chan_sema_pkg::*;
#(
  parameter int unsigned CNT_W   = SEMA_CNT_W,
  parameter int unsigned REG_W   = SEMA_REG_W,
  parameter int unsigned CNT_LSB = SEMA_CNT_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_wr_en,
  input  logic [REG_W-1:0] inc_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             clr_wr_en,
  input  logic [CNT_W-1:0] clr_wr_data,
  input  logic             dec_req,
  output logic             dec_grant,
  output logic             dec_stall,
  input  logic             eng_err,
  output logic             chan_active
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] add_val;
  sema_ctl_t        ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  sema_regif #(.CNT_W(CNT_W), .REG_W(REG_W), .CNT_LSB(CNT_LSB)) u_regif (
    .inc_wr_en   (inc_wr_en),
    .inc_wr_data (inc_wr_data),
    .clr_wr_en   (clr_wr_en),
    .clr_wr_data (clr_wr_data),
    .eng_err     (eng_err),
    .cnt_q       (cnt_q),
    .add_val     (add_val),
    .kill        (ctl.kill),
    .rd_data     (reg_rd_data)
  );

  sema_grant #(.CNT_W(CNT_W)) u_grant (
    .dec_req (dec_req),
    .kill    (ctl.kill),
    .cnt_q   (cnt_q),
    .add_val (add_val),
    .grant   (ctl.grant),
    .stall   (dec_stall)
  );

  sema_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .add_val (add_val),
    .grant   (ctl.grant),
    .kill    (ctl.kill),
    .cnt_q   (cnt_q)
  );

  assign dec_grant   = ctl.grant;
  assign chan_active = (cnt_q != '0);

  a_r8_error_blocks_grant: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_err |-> !dec_grant);

  a_r11_stall_at_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dec_req && reg_rd_data[CNT_LSB +: CNT_W] == '0 &&
     !(inc_wr_en && inc_wr_data[CNT_W-1:0] != '0)) |-> (dec_stall && !dec_grant));

  a_r7_error_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_err |=> (!chan_active && reg_rd_data == '0));
endmodule

// File: tb/sim_chan_sema_ctrl.sv
module sim_chan_sema_ctrl;
  logic        clk;
  logic        rst_n;
  logic        inc_wr_en;
  logic [31:0] inc_wr_data;
  logic [31:0] reg_rd_data;
  logic        clr_wr_en;
  logic [7:0]  clr_wr_data;
  logic        dec_req;
  logic        dec_grant;
  logic        dec_stall;
  logic        eng_err;
  logic        chan_active;

  int checks;
  int failures;
  bit done;

  chan_sema_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .inc_wr_en(inc_wr_en), .inc_wr_data(inc_wr_data), .reg_rd_data(reg_rd_data),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .dec_req(dec_req), .dec_grant(dec_grant), .dec_stall(dec_stall),
    .eng_err(eng_err), .chan_active(chan_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    inc_wr_en = 1'b0; inc_wr_data = '0;
    clr_wr_en = 1'b0; clr_wr_data = '0;
    dec_req = 1'b0; eng_err = 1'b0;
  endtask

  task automatic add(input logic [31:0] v);
    inc_wr_en = 1'b1; inc_wr_data = v;
    step();
    inc_wr_en = 1'b0; inc_wr_data = '0;
  endtask

  function automatic logic [7:0] cnt();
    return reg_rd_data[23:16];
  endfunction

  task automatic t_reset();
    chk("R1 count", {24'd0, cnt()}, 32'd0);
    chk("R1 active", {31'd0, chan_active}, 32'd0);
    chk("R1 grant", {31'd0, dec_grant}, 32'd0);
    chk("R1 stall", {31'd0, dec_stall}, 32'd0);
  endtask

  task automatic t_add();
    add(32'h0000_0003);
    chk("R2 add 3", {24'd0, cnt()}, 32'd3);
    chk("R5 read layout", reg_rd_data, 32'h0003_0000);
    chk("R9 active", {31'd0, chan_active}, 32'd1);
    add(32'hABCD_0105);
    chk("R2 upper bits ignored", {24'd0, cnt()}, 32'd8);
    chk("R5 incr field reads zero", {24'd0, reg_rd_data[7:0]}, 32'd0);
  endtask

  task automatic t_net();
    inc_wr_en = 1'b1; inc_wr_data = 32'd2; dec_req = 1'b1;
    #1;
    chk("R10 grant with add", {31'd0, dec_grant}, 32'd1);
    @(negedge clk);
    inc_wr_en = 1'b0; inc_wr_data = '0; dec_req = 1'b0;
    chk("R3 net +1", {24'd0, cnt()}, 32'd9);
    dec_req = 1'b1;
    #1;
    chk("R10 grant nonzero", {31'd0, dec_grant}, 32'd1);
    @(negedge clk);
    dec_req = 1'b0;
    chk("R10 dec by one", {24'd0, cnt()}, 32'd8);
  endtask

  task automatic t_clear();
    clr_wr_en = 1'b1; clr_wr_data = 8'h12;
    step();
    clr_wr_en = 1'b0;
    chk("R6 wrong key ignored", {24'd0, cnt()}, 32'd8);
    clr_wr_en = 1'b1; clr_wr_data = 8'hFF;
    step();
    clr_wr_en = 1'b0; clr_wr_data = '0;
    chk("R6 clear", {24'd0, cnt()}, 32'd0);
    chk("R9 inactive", {31'd0, chan_active}, 32'd0);
  endtask

  task automatic t_stall();
    dec_req = 1'b1;
    #1;
    chk("R11 stall at zero", {31'd0, dec_stall}, 32'd1);
    chk("R11 no grant at zero", {31'd0, dec_grant}, 32'd0);
    for (int i = 0; i < 3; i++) step();
    chk("R11 still stalled", {31'd0, dec_stall}, 32'd1);
    chk("R11 count held", {24'd0, cnt()}, 32'd0);
    inc_wr_en = 1'b1; inc_wr_data = 32'd1;
    #1;
    chk("R10 grant on same-cycle add", {31'd0, dec_grant}, 32'd1);
    chk("R11 stall released", {31'd0, dec_stall}, 32'd0);
    @(negedge clk);
    inc_wr_en = 1'b0; inc_wr_data = '0; dec_req = 1'b0;
    chk("R3 add 1 minus dec", {24'd0, cnt()}, 32'd0);
  endtask

  task automatic t_sat();
    add(32'd250);
    add(32'd10);
    chk("R4 saturate", {24'd0, cnt()}, 32'd255);
    inc_wr_en = 1'b1; inc_wr_data = 32'd1; dec_req = 1'b1;
    step();
    inc_wr_en = 1'b0; inc_wr_data = '0; dec_req = 1'b0;
    chk("R4 net at max", {24'd0, cnt()}, 32'd255);
    inc_wr_en = 1'b1; inc_wr_data = 32'd200; dec_req = 1'b1;
    step();
    inc_wr_en = 1'b0; inc_wr_data = '0; dec_req = 1'b0;
    chk("R4 big add with dec", {24'd0, cnt()}, 32'd255);
  endtask

  task automatic t_err();
    eng_err = 1'b1; inc_wr_en = 1'b1; inc_wr_data = 32'd5; dec_req = 1'b1;
    #1;
    chk("R8 no grant on error", {31'd0, dec_grant}, 32'd0);
    @(negedge clk);
    eng_err = 1'b0; inc_wr_en = 1'b0; inc_wr_data = '0; dec_req = 1'b0;
    chk("R7 error clears", {24'd0, cnt()}, 32'd0);
    add(32'd4);
    chk("R2 add after error", {24'd0, cnt()}, 32'd4);
    clr_wr_en = 1'b1; clr_wr_data = 8'hFF; inc_wr_en = 1'b1; inc_wr_data = 32'd9;
    dec_req = 1'b1;
    #1;
    chk("R8 no grant on clear", {31'd0, dec_grant}, 32'd0);
    @(negedge clk);
    idle_inputs();
    chk("R8 clear beats add", {24'd0, cnt()}, 32'd0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add();
    t_net();
    t_clear();
    t_stall();
    t_sat();
    t_err();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule